// File: doc/BRIEF.md
# Cluster Scratchpad Crossbar

This block connects eight processing elements to a shared 32 KB data scratchpad split into four word-interleaved banks. Access happens in two stages. First, the PEs are taken in pairs, and a 2:1 concentrator picks one request from each pair, which gives four request streams. Second, a 4x4 crossbar sends each stream to the bank named by its address, and a per-bank arbiter picks one stream whenever several of them want the same bank. A requester that loses at either stage simply sees its ready line low and keeps its request until a later cycle.

Each PE has a single-word request interface: request, write enable, byte address and write data in; ready, read-valid and read data out. A request completes in the cycle where ready is high. Read data comes back on the following cycle, routed to the PE that issued it. Both arbitration stages rotate their priority, so no requester is held off indefinitely. The banks are synchronous single-port word RAMs held inside the block.

Top module: `cluster_spad_xbar`

## Requirements
- R1: The bank is taken from byte-address bits [3:2] and the word within the bank from bits [14:4], so requests to words 0x0 and 0x4 can complete in the same cycle, while 0x0 and 0x10 cannot.
- R2: A read completed with ready high in cycle t raises read-valid for that PE in cycle t+1, with the word stored at that address. The value is the last one written there.
- R3: In any cycle, at most one PE completes an access to a given bank. The other PEs aiming at that bank see ready low.
- R4: In any cycle, at most one PE of each pair (PE 2k and PE 2k+1) sees ready high, so no more than four accesses complete per cycle.
- R5: Within a pair, after one PE completes, the other PE wins the pair on the next cycle if it is requesting.
- R6: When four streams hold requests to the same bank, the bank serves exactly one per cycle and all four finish within four cycles.
- R7: Ready is never high for a PE whose request line is low.
- R8: While reset is high, every ready and read-valid output is low, even if requests are present.
- R9: A completed write raises no read-valid on the next cycle.
- R10: Four requests from different pairs that target four different banks all complete in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_req_i | input | N_PE | Per-PE request |
| pe_we_i | input | N_PE | Per-PE write enable (1 = write, 0 = read) |
| pe_addr_i | input | N_PE x ADDR_W | Per-PE byte address |
| pe_wdata_i | input | N_PE x DATA_W | Per-PE write data |
| pe_ready_o | output | N_PE | Request accepted this cycle |
| pe_rvalid_o | output | N_PE | Read data valid (one cycle after a read is accepted) |
| pe_rdata_o | output | N_PE x DATA_W | Per-PE read data |

## Verification
The assertions assume that a PE whose ready is low keeps its request, write enable, address and data unchanged on the next cycle. This matters most for the pair-alternation property, because the concentrator's priority only moves when a request is accepted. The bench keeps to this assumption. It drives every request on the falling edge and leaves a request unchanged until it observes ready high, and it withdraws or replaces a request only after that acceptance. The bench reads only addresses it has already written, so every returned word has a known expected value.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // Byte-offset bits below the word address (32-bit words).
  localparam int BYTE_OFS_W = 2;
endpackage

// File: rtl/spad_rr_arb.sv
// Round-robin arbiter; N must be a power of two (pointer wraps naturally).
module spad_rr_arb #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] cand;

  // Scan from the lowest priority upward so the highest-priority requester wins last.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    cand    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      cand = ptr + IW'(i);
      if (req[cand]) begin
        gnt       = '0;
        gnt[cand] = 1'b1;
        gnt_idx   = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance && |req) begin
      ptr <= gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/spad_concentrator.sv
// Merges a pair of PE request ports into one stream.
module spad_concentrator #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           in_req,
  input  logic [1:0]           in_we,
  input  logic [1:0][ADDR_W-1:0] in_addr,
  input  logic [1:0][DATA_W-1:0] in_wdata,
  output logic [1:0]           in_ready,
  output logic                 out_valid,
  output logic                 out_we,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [DATA_W-1:0]    out_wdata,
  input  logic                 out_accept
);
  logic [1:0] sel;
  logic       sel_idx;

  spad_rr_arb #(.N(2)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (in_req),
    .advance (out_accept),
    .gnt     (sel),
    .gnt_idx (sel_idx)
  );

  assign out_valid = |sel;
  assign out_we    = in_we[sel_idx];
  assign out_addr  = in_addr[sel_idx];
  assign out_wdata = in_wdata[sel_idx];
  assign in_ready  = sel & {2{out_accept}};
endmodule

// File: rtl/spad_bank.sv
// Single-port synchronous word RAM, shaped for block-RAM inference.
module spad_bank #(
  parameter  int DATA_W = 32,
  parameter  int IDX_W  = 11,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/cluster_spad_xbar.sv
module cluster_spad_xbar #(
  parameter  int N_PE      = 8,
  parameter  int N_BANK    = 4,
  parameter  int DATA_W    = 32,
  parameter  int MEM_BYTES = 32768,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PE-1:0]               pe_req_i,
  input  logic [N_PE-1:0]               pe_we_i,
  input  logic [N_PE-1:0][ADDR_W-1:0]   pe_addr_i,
  input  logic [N_PE-1:0][DATA_W-1:0]   pe_wdata_i,
  output logic [N_PE-1:0]               pe_ready_o,
  output logic [N_PE-1:0]               pe_rvalid_o,
  output logic [N_PE-1:0][DATA_W-1:0]   pe_rdata_o
);
  import spad_pkg::BYTE_OFS_W;

  localparam int N_STR  = N_PE / 2;
  localparam int BSEL_W = $clog2(N_BANK);
  localparam int SIDX_W = $clog2(N_STR);
  localparam int WIDX_W = ADDR_W - BYTE_OFS_W - BSEL_W;

  logic [N_STR-1:0]               s_valid, s_we, s_accept;
  logic [N_STR-1:0][ADDR_W-1:0]   s_addr;
  logic [N_STR-1:0][DATA_W-1:0]   s_wdata;
  logic [N_STR-1:0][BSEL_W-1:0]   s_bank;
  logic [N_BANK-1:0][N_STR-1:0]   b_req, b_gnt;
  logic [N_BANK-1:0][SIDX_W-1:0]  b_win;
  logic [N_BANK-1:0][DATA_W-1:0]  b_rdata;

  // Stage 1: pair concentrators
  for (genvar k = 0; k < N_STR; k++) begin : g_conc
    spad_concentrator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_conc (
      .clk        (clk),
      .rst        (rst),
      .in_req     (pe_req_i[2*k +: 2]),
      .in_we      (pe_we_i[2*k +: 2]),
      .in_addr    (pe_addr_i[2*k +: 2]),
      .in_wdata   (pe_wdata_i[2*k +: 2]),
      .in_ready   (pe_ready_o[2*k +: 2]),
      .out_valid  (s_valid[k]),
      .out_we     (s_we[k]),
      .out_addr   (s_addr[k]),
      .out_wdata  (s_wdata[k]),
      .out_accept (s_accept[k])
    );
    assign s_bank[k] = s_addr[k][BYTE_OFS_W +: BSEL_W];
  end

  // Stage 2: per-bank request vectors and stream acceptance
  always_comb begin
    for (int b = 0; b < N_BANK; b++) begin
      for (int k = 0; k < N_STR; k++) begin
        b_req[b][k] = s_valid[k] && (s_bank[k] == BSEL_W'(b));
      end
    end
    for (int k = 0; k < N_STR; k++) begin
      s_accept[k] = b_gnt[s_bank[k]][k] && !rst;
    end
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    spad_rr_arb #(.N(N_STR)) u_barb (
      .clk     (clk),
      .rst     (rst),
      .req     (b_req[b]),
      .advance (1'b1),
      .gnt     (b_gnt[b]),
      .gnt_idx (b_win[b])
    );

    spad_bank #(.DATA_W(DATA_W), .IDX_W(WIDX_W)) u_ram (
      .clk   (clk),
      .en    (|b_gnt[b] && !rst),
      .we    (s_we[b_win[b]]),
      .idx   (s_addr[b_win[b]][ADDR_W-1 -: WIDX_W]),
      .wdata (s_wdata[b_win[b]]),
      .rdata (b_rdata[b])
    );
  end

  // Response steering: remember which bank each PE read from
  logic [N_PE-1:0]             rsp_v_q;
  logic [N_PE-1:0][BSEL_W-1:0] rsp_bank_q;

  always_ff @(posedge clk) begin
    if (rst) rsp_v_q <= '0;
    else     rsp_v_q <= pe_ready_o & ~pe_we_i;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PE; p++) begin
      rsp_bank_q[p] <= pe_addr_i[p][BYTE_OFS_W +: BSEL_W];
    end
  end

  assign pe_rvalid_o = rsp_v_q;
  always_comb begin
    for (int p = 0; p < N_PE; p++) begin
      pe_rdata_o[p] = b_rdata[rsp_bank_q[p]];
    end
  end
endmodule

// File: rtl/cluster_spad_xbar_checker.sv
module cluster_spad_xbar_checker #(
  parameter int N_PE   = 8,
  parameter int N_BANK = 4,
  parameter int ADDR_W = 15
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_PE-1:0]             pe_req_i,
  input logic [N_PE-1:0]             pe_we_i,
  input logic [N_PE-1:0][ADDR_W-1:0] pe_addr_i,
  input logic [N_PE-1:0]             pe_ready_o,
  input logic [N_PE-1:0]             pe_rvalid_o
);
  localparam int BSEL_W = $clog2(N_BANK);

  for (genvar b = 0; b < N_BANK; b++) begin : g_b
    logic [N_PE-1:0] hit;
    always_comb begin
      for (int p = 0; p < N_PE; p++) begin
        hit[p] = pe_ready_o[p] && (pe_addr_i[p][2 +: BSEL_W] == BSEL_W'(b));
      end
    end
    assert_bank_single_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));
  end

  for (genvar k = 0; k < N_PE / 2; k++) begin : g_pair
    assert_pair_single_R4: assert property (@(posedge clk) disable iff (rst)
      !(pe_ready_o[2*k] && pe_ready_o[2*k+1]));
    assert_pair_turn_a_R5: assert property (@(posedge clk) disable iff (rst)
      pe_ready_o[2*k] |=> !(pe_req_i[2*k+1] && pe_ready_o[2*k]));
    assert_pair_turn_b_R5: assert property (@(posedge clk) disable iff (rst)
      pe_ready_o[2*k+1] |=> !(pe_req_i[2*k] && pe_ready_o[2*k+1]));
  end

  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (pe_ready_o[p] && !pe_we_i[p]) |=> pe_rvalid_o[p]);
    assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
      !(pe_ready_o[p] && !pe_we_i[p]) |=> !pe_rvalid_o[p]);
  end

  assert_ready_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
    (pe_ready_o & ~pe_req_i) == '0);
endmodule

bind cluster_spad_xbar cluster_spad_xbar_checker #(
  .N_PE(N_PE), .N_BANK(N_BANK), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pe_req_i    (pe_req_i),
  .pe_we_i     (pe_we_i),
  .pe_addr_i   (pe_addr_i),
  .pe_ready_o  (pe_ready_o),
  .pe_rvalid_o (pe_rvalid_o)
);

// File: tb/cluster_spad_xbar_tb.sv
`timescale 1ns/1ps
module cluster_spad_xbar_tb;
  localparam int NP = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NP-1:0]        req_r = '0;
  logic [NP-1:0]        we_r = '0;
  logic [NP-1:0][14:0]  addr_r = '0;
  logic [NP-1:0][31:0]  wdata_r = '0;
  logic [NP-1:0]        ready_w, rvalid_w;
  logic [NP-1:0][31:0]  rdata_w;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [int];
  logic [NP-1:0] pend = '0;
  logic [31:0]   exp_rd [NP];

  always #2 clk = ~clk;

  cluster_spad_xbar u_dut (
    .clk(clk), .rst(rst),
    .pe_req_i(req_r), .pe_we_i(we_r), .pe_addr_i(addr_r), .pe_wdata_i(wdata_r),
    .pe_ready_o(ready_w), .pe_rvalid_o(rvalid_w), .pe_rdata_o(rdata_w)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Called just after a falling edge with inputs set; returns the grant vector.
  task automatic step(output logic [NP-1:0] gr);
    #1;
    gr = ready_w;
    chk((gr & ~req_r) == '0, "R7 ready without request", {24'h0, gr}, {24'h0, gr & req_r});
    for (int p = 0; p < NP; p++) begin
      if (gr[p]) begin
        if (we_r[p]) model[int'(addr_r[p] >> 2)] = wdata_r[p];
        else begin
          pend[p]   = 1'b1;
          exp_rd[p] = model.exists(int'(addr_r[p] >> 2)) ? model[int'(addr_r[p] >> 2)] : 32'hx;
        end
      end
    end
    @(negedge clk);
    chk(rvalid_w == pend, "R2/R9 read-valid pattern", {24'h0, rvalid_w}, {24'h0, pend});
    for (int p = 0; p < NP; p++) begin
      if (pend[p]) chk(rdata_w[p] === exp_rd[p], "R2 read data", rdata_w[p], exp_rd[p]);
    end
    pend  = '0;
    req_r = req_r & ~gr;
  endtask

  task automatic set_req(input int p, input bit w, input logic [14:0] a, input logic [31:0] d);
    req_r[p] = 1'b1; we_r[p] = w; addr_r[p] = a; wdata_r[p] = d;
  endtask

  task automatic t_reset();
    req_r = '1; we_r = '0;
    @(negedge clk); #1;
    chk(ready_w == '0, "R8 ready in reset", {24'h0, ready_w}, 32'h0);
    chk(rvalid_w == '0, "R8 rvalid in reset", {24'h0, rvalid_w}, 32'h0);
    @(negedge clk);
    rst = 1'b0; req_r = '0;
    @(negedge clk);
  endtask

  task automatic t_preload();
    logic [NP-1:0] gr;
    for (int i = 0; i < 20; i++) begin
      set_req(0, 1'b1, 15'(i * 4), 32'hA500_0000 + 32'(i * 32'h111));
      step(gr);
      chk(gr == 8'h01, "R9 single write accepted", {24'h0, gr}, 32'h01);
    end
    set_req(7, 1'b1, 15'h7FFC, 32'hDEAD_BEEF);
    step(gr);
    chk(gr == 8'h80, "R1 top-address write", {24'h0, gr}, 32'h80);
    set_req(2, 1'b0, 15'h7FFC, 32'h0);
    step(gr);
    chk(gr == 8'h04, "R1 top-address read", {24'h0, gr}, 32'h04);
  endtask

  task automatic t_bank_map();
    logic [NP-1:0] gr;
    set_req(0, 1'b0, 15'h000, 32'h0);
    set_req(2, 1'b0, 15'h004, 32'h0);
    step(gr);
    chk(gr == 8'h05, "R1 adjacent words in different banks", {24'h0, gr}, 32'h05);
    set_req(0, 1'b0, 15'h000, 32'h0);
    set_req(2, 1'b0, 15'h010, 32'h0);
    step(gr);
    chk($countones(gr) == 1, "R1 stride-16 words share a bank", {24'h0, gr}, 32'h1);
    step(gr);
    chk($countones(gr) == 1 && req_r == '0, "R3 loser served next cycle", {24'h0, gr}, 32'h1);
  endtask

  task automatic t_disjoint();
    logic [NP-1:0] gr;
    for (int i = 0; i < 4; i++) set_req(2 * i + 1, 1'b0, 15'(32'h40 + i * 4), 32'h0);
    step(gr);
    chk(gr == 8'hAA, "R10 four disjoint banks in one cycle", {24'h0, gr}, 32'hAA);
  endtask

  task automatic t_conflict();
    logic [NP-1:0] gr;
    int cycles = 0;
    for (int i = 0; i < 4; i++) set_req(2 * i, 1'b0, 15'(i * 16), 32'h0);
    while (req_r != '0 && cycles < 8) begin
      step(gr);
      cycles++;
      chk($countones(gr) == 1, "R3 one grant per bank per cycle", {24'h0, gr}, 32'h1);
    end
    chk(cycles == 4, "R6 four contenders served in four cycles", 32'(cycles), 32'd4);
  endtask

  task automatic t_pair();
    logic [NP-1:0] gr;
    logic [NP-1:0] prev = '0;
    for (int c = 0; c < 6; c++) begin
      set_req(0, 1'b0, 15'h004, 32'h0);
      set_req(1, 1'b0, 15'h008, 32'h0);
      step(gr);
      chk($countones(gr[1:0]) == 1, "R4 one grant per pair", {24'h0, gr}, 32'h1);
      if (c > 0) chk(gr[1:0] != prev[1:0], "R5 pair alternates", {24'h0, gr}, {24'h0, ~prev & 8'h03});
      prev = gr;
    end
    req_r = '0;
  endtask

  task automatic t_write_no_rvalid();
    logic [NP-1:0] gr;
    set_req(3, 1'b1, 15'h0044, 32'h1234_5678);
    set_req(5, 1'b1, 15'h0048, 32'h8765_4321);
    step(gr);
    chk(gr == 8'h28, "R9 writes accepted", {24'h0, gr}, 32'h28);
    set_req(4, 1'b0, 15'h0044, 32'h0);
    set_req(6, 1'b0, 15'h0048, 32'h0);
    step(gr);
    chk(gr == 8'h50, "R2 read-after-write accepted", {24'h0, gr}, 32'h50);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    t_reset();
    t_preload();
    t_bank_map();
    t_disjoint();
    t_conflict();
    t_pair();
    t_write_no_rvalid();
    @(negedge clk);
    summary();
  end
endmodule